// File: doc/BRIEF.md
# Register Write Sequence Engine

This block runs a stored list of bit-field writes into a bank of control registers without help from the host. The host first loads step records into a 128-entry step memory through a simple write port. It then holds the sequence-enable input high, places a start index on its input and pulses the start input. From that point the engine executes one step per engine tick, in ascending index order. Each step is a read-modify-write of one field of one control register, and a step may add a delay before the next one. The run ends on the first step that carries the end flag.

When the run completes, a sticky completion flag is raised. A run that executes the top memory entry without finding an end flag also stops, and it raises a separate sticky wrap flag instead. The host can abort a run at any time. While a run is in progress, host access to the control registers is refused. The engine advances only on ticks of a divided system clock, and that tick is gated by the oscillator enable input.

Top module: `wseq_engine`

## Requirements
- R1: A run starts only when `seq_start` is high in a cycle where `seq_en` is high and `busy` is low. The first step executed is the one at `start_idx`. A start pulse while `seq_en` is low has no effect.
- R2: A step record is laid out as follows:
  - bit 28: end flag
  - bits 27:24: delay code
  - bits 23:16: value
  - bits 15:12: field width minus one
  - bits 11:8: field low bit
  - bits 7:0: register address

  The step replaces bits low..low+width-1 of the addressed register with the low bits of the value. All other bits are kept, and field bits above bit 7 are dropped.
- R3: Steps execute at consecutive ascending indices, one per tick, until a step with the end flag set has executed. No step after it is executed. With one tick per clock and no delays, `busy` stays high for exactly as many cycles as steps executed.
- R4: `done_irq` goes high when the end-flagged step completes. It stays high until `stat_clr` is pulsed.
- R5: A delay code d greater than 0 adds 2^d ticks after its step, before the next step or before completion. Code 0 adds nothing.
- R6: `seq_abort` ends a run in the same cycle. `busy` is low afterwards, no further step writes any register, and `done_irq` is not raised.
- R7: `busy` is low after reset. It is high from the cycle after an accepted start until the run completes, wraps or is aborted.
- R8: While `busy` is high, host reads return 0 and host writes change nothing. `host_err` is high for any host read or write in those cycles.
- R9: `cur_idx` shows the index of the step being executed. After completion it holds the index of the last executed step. It is 0 after reset.
- R10: The engine advances only on ticks. A tick occurs once every DIV clocks while `osc_en` is high. With `osc_en` low, a started run makes no progress and stays busy.
- R11: If the step at the top index (127) executes without the end flag, the run stops, `wrap_err` goes high and `done_irq` stays low. `stat_clr` clears `wrap_err`.
- R12: While idle, host writes set the addressed register and host reads return its value. Addresses at or above the bank size (16) are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| osc_en | input | 1 | oscillator enable; gates engine ticks |
| seq_en | input | 1 | sequence engine enable |
| seq_start | input | 1 | start pulse |
| start_idx | input | 7 | first step index of a run |
| seq_abort | input | 1 | abort pulse |
| stat_clr | input | 1 | clears done_irq and wrap_err |
| step_we | input | 1 | step memory write strobe |
| step_waddr | input | 7 | step memory write index |
| step_wdata | input | 29 | step record to store |
| host_wr | input | 1 | host register write strobe |
| host_rd | input | 1 | host register read strobe |
| host_addr | input | 8 | host register address |
| host_wdata | input | 8 | host write data |
| host_rdata | output | 8 | host read data (0 when refused) |
| host_err | output | 1 | host access refused while busy |
| busy | output | 1 | run in progress |
| done_irq | output | 1 | sticky completion flag |
| wrap_err | output | 1 | sticky index-wrap flag |
| cur_idx | output | 7 | index of current or last executed step |

## Verification
The field merge is swept over every low-bit position from 0 to 9 and every width from 1 to 8 on a fixed register pattern. This separates correct masking from shifting errors and from leakage above bit 7. Multi-step runs write overlapping fields of one register, which shows the steps executed in order. A guard step placed after the end flag shows where the run stops. Mixed delay codes are checked against a computed busy length, and abort, oscillator-off, wrap at the top index and lockout runs each show a different way the run is cut short or held.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    localparam int WS_REG_W  = 8;
    localparam int WS_ADDR_W = 8;
    localparam int WS_POS_W  = 4;
    localparam int WS_DLY_W  = 4;
    localparam int WS_CNT_W  = 1 << WS_DLY_W;

    typedef struct packed {
        logic                 last;
        logic [WS_DLY_W-1:0]  dly;
        logic [WS_REG_W-1:0]  val;
        logic [WS_POS_W-1:0]  wm1;
        logic [WS_POS_W-1:0]  lsb;
        logic [WS_ADDR_W-1:0] addr;
    } wseq_step_t;

    localparam int WS_STEP_W = $bits(wseq_step_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_WAIT = 2'd2
    } wseq_state_e;

    function automatic logic [WS_REG_W-1:0] field_merge(
        input logic [WS_REG_W-1:0] old_v,
        input logic [WS_REG_W-1:0] new_v,
        input logic [WS_POS_W-1:0] lsb,
        input logic [WS_POS_W-1:0] wm1
    );
        logic [31:0] mask;
        logic [31:0] shifted;
        mask    = ((32'd1 << ({1'b0, wm1} + 5'd1)) - 32'd1) << lsb;
        shifted = {24'd0, new_v} << lsb;
        return (old_v & ~mask[WS_REG_W-1:0]) | (shifted[WS_REG_W-1:0] & mask[WS_REG_W-1:0]);
    endfunction

    function automatic logic [WS_CNT_W-1:0] delay_ticks(input logic [WS_DLY_W-1:0] code);
        return WS_CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/wseq_tick_gen.sv
module wseq_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (osc_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = osc_en && (cnt == LAST);

    a_r10_tick_needs_osc: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> !tick);

endmodule

// File: rtl/wseq_step_mem.sv
module wseq_step_mem
    import wseq_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  wseq_step_t       wdata,
    input  logic [IDX_W-1:0] raddr,
    output wseq_step_t       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    wseq_step_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/wseq_delay_timer.sv
module wseq_delay_timer
    import wseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                load,
    input  logic                clear,
    input  logic [WS_DLY_W-1:0] code,
    output logic                expire
);
    logic [WS_CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= delay_ticks(code);
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = tick && !load && (cnt == WS_CNT_W'(1));

    a_r5_loaded_nonzero: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |=> (cnt != '0));

    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load && !clear) |=> $stable(cnt));

endmodule

// File: rtl/wseq_reg_bank.sv
module wseq_reg_bank
    import wseq_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lock,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [WS_ADDR_W-1:0] host_addr,
    input  logic [WS_REG_W-1:0]  host_wdata,
    output logic [WS_REG_W-1:0]  host_rdata,
    output logic                 host_err,
    input  logic                 eng_we,
    input  logic [WS_ADDR_W-1:0] eng_addr,
    input  logic [WS_REG_W-1:0]  eng_val,
    input  logic [WS_POS_W-1:0]  eng_lsb,
    input  logic [WS_POS_W-1:0]  eng_wm1
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [NUM_REGS-1:0][WS_REG_W-1:0] bank;
    logic             host_hit, eng_hit;
    logic [SEL_W-1:0] host_sel, eng_sel;

    assign host_hit = int'(host_addr) < NUM_REGS;
    assign eng_hit  = int'(eng_addr) < NUM_REGS;
    assign host_sel = SEL_W'(host_addr);
    assign eng_sel  = SEL_W'(eng_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (eng_we && eng_hit) begin
            bank[eng_sel] <= field_merge(bank[eng_sel], eng_val, eng_lsb, eng_wm1);
        end else if (host_wr && !lock && host_hit) begin
            bank[host_sel] <= host_wdata;
        end
    end

    assign host_rdata = (host_rd && !lock && host_hit) ? bank[host_sel] : '0;
    assign host_err   = lock && (host_wr || host_rd);

    a_r8_locked_bank_hold: assert property (@(posedge clk) disable iff (rst)
        (lock && !eng_we) |=> $stable(bank));

    a_r12_idle_no_engine: assert property (@(posedge clk) disable iff (rst)
        !lock |-> !eng_we);

endmodule

// File: rtl/wseq_engine.sv
module wseq_engine
    import wseq_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int NUM_REGS = 16,
    parameter int DIV      = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 osc_en,
    input  logic                 seq_en,
    input  logic                 seq_start,
    input  logic [IDX_W-1:0]     start_idx,
    input  logic                 seq_abort,
    input  logic                 stat_clr,
    input  logic                 step_we,
    input  logic [IDX_W-1:0]     step_waddr,
    input  logic [WS_STEP_W-1:0] step_wdata,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic [WS_ADDR_W-1:0] host_addr,
    input  logic [WS_REG_W-1:0]  host_wdata,
    output logic [WS_REG_W-1:0]  host_rdata,
    output logic                 host_err,
    output logic                 busy,
    output logic                 done_irq,
    output logic                 wrap_err,
    output logic [IDX_W-1:0]     cur_idx
);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;

    wseq_state_e      state;
    logic [IDX_W-1:0] idx;
    wseq_step_t       rec;
    logic             tick, tmr_expire;
    logic             step_fire, wait_done, has_dly, advance;

    wseq_tick_gen #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .osc_en (osc_en),
        .tick   (tick)
    );

    wseq_step_mem #(.IDX_W(IDX_W)) u_mem (
        .clk   (clk),
        .we    (step_we),
        .waddr (step_waddr),
        .wdata (wseq_step_t'(step_wdata)),
        .raddr (idx),
        .rdata (rec)
    );

    assign has_dly   = rec.dly != '0;
    assign step_fire = (state == ST_STEP) && tick && !seq_abort;
    assign wait_done = (state == ST_WAIT) && tmr_expire && !seq_abort;
    assign advance   = (step_fire && !has_dly) || wait_done;

    wseq_delay_timer u_tmr (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .load   (step_fire && has_dly),
        .clear  (seq_abort),
        .code   (rec.dly),
        .expire (tmr_expire)
    );

    wseq_reg_bank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .lock       (busy),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_err   (host_err),
        .eng_we     (step_fire),
        .eng_addr   (rec.addr),
        .eng_val    (rec.val),
        .eng_lsb    (rec.lsb),
        .eng_wm1    (rec.wm1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            done_irq <= 1'b0;
            wrap_err <= 1'b0;
        end else begin
            if (stat_clr) begin
                done_irq <= 1'b0;
                wrap_err <= 1'b0;
            end
            if (state == ST_IDLE) begin
                if (seq_start && seq_en) begin
                    state <= ST_STEP;
                    idx   <= start_idx;
                end
            end else if (seq_abort) begin
                state <= ST_IDLE;
            end else if (step_fire && has_dly) begin
                state <= ST_WAIT;
            end else if (advance) begin
                if (rec.last) begin
                    state    <= ST_IDLE;
                    done_irq <= 1'b1;
                end else if (idx == IDX_TOP) begin
                    state    <= ST_IDLE;
                    wrap_err <= 1'b1;
                end else begin
                    idx   <= idx + 1'b1;
                    state <= ST_STEP;
                end
            end
        end
    end

    assign busy    = state != ST_IDLE;
    assign cur_idx = idx;

    a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(seq_start && seq_en));

    a_r6_abort_halts: assert property (@(posedge clk) disable iff (rst)
        seq_abort |=> !busy);

    a_r4_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !stat_clr) |=> done_irq);

    a_r11_wrap_sticky: assert property (@(posedge clk) disable iff (rst)
        (wrap_err && !stat_clr) |=> wrap_err);

    a_r10_no_tick_no_move: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(cur_idx));

    a_r3_index_steps_by_one: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && cur_idx != $past(cur_idx))
            |-> cur_idx == IDX_W'($past(cur_idx) + 1'b1));

endmodule

// File: tb/wseq_engine_test.sv
`timescale 1ns/1ps
module wseq_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_en = 1'b1, seq_en = 1'b0, seq_start = 1'b0, seq_abort = 1'b0, stat_clr = 1'b0;
    logic [6:0]  start_idx = '0;
    logic        step_we = 1'b0;
    logic [6:0]  step_waddr = '0;
    logic [28:0] step_wdata = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_err, busy, done_irq, wrap_err;
    logic [6:0]  cur_idx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wseq_engine #(.IDX_W(7), .NUM_REGS(16), .DIV(1)) uut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .seq_en(seq_en), .seq_start(seq_start),
        .start_idx(start_idx), .seq_abort(seq_abort), .stat_clr(stat_clr),
        .step_we(step_we), .step_waddr(step_waddr), .step_wdata(step_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_err(host_err), .busy(busy), .done_irq(done_irq),
        .wrap_err(wrap_err), .cur_idx(cur_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_step(input int idx, input bit last, input int dly, input int val,
                            input int wm1, input int lsb, input int addr);
        @(negedge clk);
        step_waddr = 7'(idx);
        step_wdata = {last, 4'(dly), 8'(val), 4'(wm1), 4'(lsb), 8'(addr)};
        step_we = 1'b1;
        @(negedge clk);
        step_we = 1'b0;
    endtask

    task automatic hwrite(input int a, input int d);
        @(negedge clk);
        host_addr = 8'(a); host_wdata = 8'(d); host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input int a, output int d, output bit e);
        @(negedge clk);
        host_addr = 8'(a); host_rd = 1'b1;
        #1;
        d = int'(host_rdata); e = host_err;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic kick(input int s);
        @(negedge clk);
        start_idx = 7'(s); seq_start = 1'b1;
        @(negedge clk);
        seq_start = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 4000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    function automatic int merge_exp(input int old_v, input int val, input int lsb, input int wm1);
        int r = 0;
        for (int i = 0; i < 8; i++) begin
            if (i >= lsb && i <= lsb + wm1) r |= ((val >> (i - lsb)) & 1) << i;
            else r |= old_v & (1 << i);
        end
        return r;
    endfunction

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d, cyc;
        bit e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state: R7 R4 R11 R9
        check(busy == 1'b0, "R7 reset busy", busy, 0);
        check(done_irq == 1'b0, "R4 reset irq", done_irq, 0);
        check(wrap_err == 1'b0, "R11 reset wrap", wrap_err, 0);
        check(cur_idx == 7'd0, "R9 reset idx", cur_idx, 0);

        // R12 host access while idle
        hwrite(2, 8'h9C);
        hread(2, d, e);
        check(d == 8'h9C && !e, "R12 host rw", d, 8'h9C);
        hwrite(200, 8'h55);
        hread(200, d, e);
        check(d == 0, "R12 out of range read", d, 0);
        hread(8, d, e);
        check(d == 0, "R12 alias write ignored", d, 0);

        // R1 start ignored with enable low
        put_step(5, 1, 0, 8'hFF, 7, 0, 2);
        kick(5);
        check(busy == 1'b0, "R1 start without enable", busy, 0);
        hread(2, d, e);
        check(d == 8'h9C, "R1 no write without enable", d, 8'h9C);
        seq_en = 1'b1;

        // R2 field merge sweep
        for (int lsb = 0; lsb < 10; lsb++) begin
            for (int wm1 = 0; wm1 < 8; wm1++) begin
                int val = (8'h5A ^ (lsb * 16 + wm1 * 3)) & 8'hFF;
                hwrite(3, 8'hA5);
                put_step(10, 1, 0, val, wm1, lsb, 3);
                kick(10);
                wait_idle(cyc);
                hread(3, d, e);
                check(d == merge_exp(8'hA5, val, lsb, wm1), "R2 field merge", d, merge_exp(8'hA5, val, lsb, wm1));
            end
        end
        pulse_clr();

        // R3 R9 R4 ordering and end flag
        put_step(20, 0, 0, 8'h11, 7, 0, 4);
        put_step(21, 0, 0, 8'h02, 3, 0, 4);
        put_step(22, 0, 0, 8'h66, 7, 0, 5);
        put_step(23, 1, 0, 8'h77, 7, 0, 6);
        put_step(24, 1, 0, 8'hEE, 7, 0, 7);
        kick(20);
        wait_idle(cyc);
        check(cyc == 4, "R3 busy cycles", cyc, 4);
        check(cur_idx == 7'd23, "R9 last index", cur_idx, 23);
        check(done_irq == 1'b1, "R4 irq set", done_irq, 1);
        hread(4, d, e);
        check(d == 8'h12, "R3 ascending order", d, 8'h12);
        hread(6, d, e);
        check(d == 8'h77, "R3 end step written", d, 8'h77);
        hread(7, d, e);
        check(d == 0, "R3 stop after end flag", d, 0);
        repeat (3) @(negedge clk);
        check(done_irq == 1'b1, "R4 irq sticky", done_irq, 1);
        pulse_clr();
        check(done_irq == 1'b0, "R4 irq cleared", done_irq, 0);

        // R5 delays
        put_step(30, 0, 2, 8'h01, 7, 0, 14);
        put_step(31, 0, 3, 8'h02, 7, 0, 14);
        put_step(32, 1, 0, 8'h03, 7, 0, 15);
        kick(30);
        wait_idle(cyc);
        check(cyc == 3 + 4 + 8, "R5 delay length", cyc, 15);
        put_step(33, 1, 1, 8'h04, 7, 0, 15);
        pulse_clr();
        kick(33);
        wait_idle(cyc);
        check(cyc == 1 + 2, "R5 delay on end step", cyc, 3);

        // R8 lockout
        hwrite(12, 8'h0F);
        put_step(50, 0, 3, 8'h21, 7, 0, 13);
        put_step(51, 1, 0, 8'h04, 3, 4, 13);
        kick(50);
        hread(12, d, e);
        check(d == 0 && e, "R8 read blocked", d, 0);
        check(e == 1'b1, "R8 error flag", e, 1);
        @(negedge clk);
        host_addr = 8'd12; host_wdata = 8'hEE; host_wr = 1'b1;
        #1;
        check(host_err == 1'b1, "R8 write error flag", host_err, 1);
        @(negedge clk);
        host_wr = 1'b0;
        check(busy == 1'b1, "R7 busy during run", busy, 1);
        wait_idle(cyc);
        hread(12, d, e);
        check(d == 8'h0F, "R8 write blocked", d, 8'h0F);
        hread(13, d, e);
        check(d == 8'h41, "R2 two-step merge", d, 8'h41);
        pulse_clr();

        // R6 abort
        put_step(40, 0, 4, 8'h33, 7, 0, 10);
        put_step(41, 1, 0, 8'hCC, 7, 0, 10);
        kick(40);
        repeat (3) @(negedge clk);
        seq_abort = 1'b1;
        @(negedge clk);
        seq_abort = 1'b0;
        check(busy == 1'b0, "R6 abort clears busy", busy, 0);
        repeat (30) @(negedge clk);
        hread(10, d, e);
        check(d == 8'h33, "R6 no write after abort", d, 8'h33);
        check(done_irq == 1'b0, "R6 no irq on abort", done_irq, 0);

        // R10 oscillator off
        put_step(60, 1, 0, 8'h5D, 7, 0, 11);
        osc_en = 1'b0;
        kick(60);
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R10 stalled busy", busy, 1);
        check(done_irq == 1'b0, "R10 no progress", done_irq, 0);
        osc_en = 1'b1;
        wait_idle(cyc);
        hread(11, d, e);
        check(d == 8'h5D, "R10 resumes", d, 8'h5D);
        pulse_clr();

        // R11 wrap at top index
        put_step(127, 0, 0, 8'h7E, 7, 0, 9);
        kick(127);
        wait_idle(cyc);
        check(cyc == 1, "R11 stop at top", cyc, 1);
        check(wrap_err == 1'b1, "R11 wrap flag", wrap_err, 1);
        check(done_irq == 1'b0, "R11 no irq", done_irq, 0);
        hread(9, d, e);
        check(d == 8'h7E, "R11 top step written", d, 8'h7E);
        pulse_clr();
        check(wrap_err == 1'b0, "R11 wrap cleared", wrap_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule